// File: doc/BRIEF.md
# Parallel-Port Register Bridge for an Acquisition Core

This block is the peripheral side of an enhanced parallel port link. A host PC reaches the configuration registers of a data-acquisition engine through it. The host runs two kinds of cycle over an 8-bit bus:

- An **address cycle** selects a register.
- **Data cycles** move a 16-bit word as two byte transfers, low byte first and high byte second.

Each cycle follows a four-phase handshake. The host pulls a strobe low. The bridge answers by raising busy. The host lets go of the strobe. The bridge then drops busy.

A direction line sets the direction of each cycle: low means the host writes, high means the host reads. During a read the bridge drives the bus through an output-enable, so the pad can be tri-stated outside the read.

The register map has six writable words:

| Address | Contents |
|---------|----------|
| 0 | Run control: start, continuous mode, trigger settings and time scale |
| 1 | Channel mask |
| 2 | Buffer length |
| 3 | Trigger threshold |
| 4 | Trigger delay |
| 5 | Converter setup |

Two read-only words, at addresses 8 and 9, report acquisition status. Reads of those two words may be held off until the acquisition engine acknowledges.

Top module: `epp_reg_bridge`

## Requirements
- R1: After reset, every configuration output is zero, `epp_busy_o` is low and `epp_data_oe_o` is low.
- R2: `epp_busy_o` rises no earlier than two clock cycles after a strobe (`epp_astb_ni` or `epp_dstb_ni`) goes low. Once high, it stays high until both strobes have been high for at least two clock cycles.
- R3: A write (`epp_write_ni` low) consists of an address cycle on `epp_astb_ni`, then two data cycles on `epp_dstb_ni`. The first data byte is bits 7:0 and the second is bits 15:8. The target register output keeps its old value after the first byte and takes the new word only when the second byte completes.
- R4: Only the defined bits are stored; other bits read back as zero. The field widths are:
  - address 0 (run control): 11 bits, bit0 start, bit1 continuous, bit2 trigger on, bit3 trigger edge, bit4 trigger channel, bit5 time-scale enable, bits 10:6 time scale;
  - address 1 (channel mask): 2 bits;
  - address 2 (buffer length): 14 bits;
  - address 3 (trigger threshold): 10 bits;
  - address 4 (trigger delay): 15 bits;
  - address 5 (converter setup): 12 bits, bits 8:0 prescaler, bit9 prescaler enable, bit10 sleep, bit11 channel select.
- R5: A read (`epp_write_ni` high) consists of an address cycle, then two data cycles. The bridge drives the low byte in the first data cycle and the high byte in the second. It asserts `epp_data_oe_o` only while `epp_busy_o` is high in a read data cycle. Both bytes come from one snapshot of the word, taken at the first byte.
- R6: Address 8 reads as follows, with all other bits zero:
  - bit15 = `err_flag_i`
  - bit14 = `run_flag_i`
  - bit10 = `smp_chan_i`
  - bits 9:0 = `sample_i`

  Address 9 reads `err_num_i` in bits 2:0, with all other bits zero.
- R7: Reads of addresses 6, 7 and 10 to 255 return zero. Writes to any address other than 0 to 5 change no register.
- R8: A data cycle whose address has bit 3 clear completes without waiting. A data cycle whose address has bit 3 set completes only when `stat_ack_i` is high or `running_i` is low. While it waits, `epp_busy_o` stays low.
- R9: Every address cycle restarts the byte order, so the next data cycle is again the low byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| epp_write_ni | input | 1 | Cycle direction: low write, high read |
| epp_astb_ni | input | 1 | Address strobe, active low |
| epp_dstb_ni | input | 1 | Data strobe, active low |
| epp_data_i | input | 8 | Bus value driven by the host |
| epp_data_o | output | 8 | Bus value driven by the bridge on reads |
| epp_data_oe_o | output | 1 | Enable for the bus pad driver |
| epp_busy_o | output | 1 | Handshake reply to the host |
| running_i | input | 1 | Acquisition is active |
| stat_ack_i | input | 1 | Engine allows a status access |
| run_flag_i | input | 1 | Status: acquisition running |
| err_flag_i | input | 1 | Status: error present |
| smp_chan_i | input | 1 | Status: channel of current sample |
| sample_i | input | 10 | Status: current sample |
| err_num_i | input | 3 | Status: error code |
| run_cfg_o | output | 11 | Run control register |
| chan_mask_o | output | 2 | Channel mask register |
| buf_size_o | output | 14 | Buffer length register |
| trig_level_o | output | 10 | Trigger threshold register |
| trig_offset_o | output | 15 | Trigger delay register |
| adc_cfg_o | output | 12 | Converter setup register |

## Verification
The bench writes each writable address with all-ones and with mixed patterns. The all-ones writes show field truncation. The mixed patterns separate a low/high byte swap from correct assembly.

Between the two bytes it samples the target output. This separates a register that updates only at the high byte from one that updates at the low byte.

Reads of status, of unmapped addresses and of read-only targets after a write show that decoding is correct. An address cycle placed after a lone low byte shows whether the byte order restarts. Status reads are repeated with the engine running, first without and then with its acknowledge, which shows the stall.

// File: rtl/epp_bridge_pkg.sv
package epp_bridge_pkg;
  localparam int BUS_W  = 8;
  localparam int WORD_W = 2 * BUS_W;

  localparam int RUN_W = 11;
  localparam int CH_W  = 2;
  localparam int BUF_W = 14;
  localparam int LVL_W = 10;
  localparam int OFS_W = 15;
  localparam int ADC_W = 12;
  localparam int SMP_W = 10;
  localparam int ERR_W = 3;

  localparam logic [BUS_W-1:0] A_RUN  = 8'd0;
  localparam logic [BUS_W-1:0] A_CHAN = 8'd1;
  localparam logic [BUS_W-1:0] A_BUF  = 8'd2;
  localparam logic [BUS_W-1:0] A_LVL  = 8'd3;
  localparam logic [BUS_W-1:0] A_OFS  = 8'd4;
  localparam logic [BUS_W-1:0] A_ADC  = 8'd5;
  localparam logic [BUS_W-1:0] A_STAT = 8'd8;
  localparam logic [BUS_W-1:0] A_ERR  = 8'd9;

  // address bit that routes an access to the engine-gated status space
  localparam int STAT_BIT = 3;

  typedef enum logic [1:0] {
    HS_IDLE,
    HS_WAIT,
    HS_HOLD
  } hs_state_e;
endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= RST_VAL;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/epp_handshake.sv
module epp_handshake
  import epp_bridge_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic astb_n_s_i,
  input  logic dstb_n_s_i,
  input  logic write_n_s_i,
  input  logic acc_high_i,
  input  logic running_i,
  input  logic int_ack_i,
  output logic busy_o,
  output logic addr_stb_o,
  output logic data_stb_o,
  output logic rd_o,
  output logic drive_o
);
  hs_state_e state_q;
  logic      is_addr_q, rd_q, busy_q;
  logic      go, released;

  assign released = astb_n_s_i && dstb_n_s_i;
  assign go = is_addr_q || !acc_high_i || int_ack_i || !running_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= HS_IDLE;
      is_addr_q <= 1'b0;
      rd_q      <= 1'b0;
      busy_q    <= 1'b0;
    end else begin
      case (state_q)
        HS_IDLE: begin
          if (!astb_n_s_i || !dstb_n_s_i) begin
            is_addr_q <= !astb_n_s_i;
            rd_q      <= write_n_s_i;
            state_q   <= HS_WAIT;
          end
        end
        HS_WAIT: begin
          if (released) begin
            state_q <= HS_IDLE;   // host abandoned the cycle
          end else if (go) begin
            busy_q  <= 1'b1;
            state_q <= HS_HOLD;
          end
        end
        HS_HOLD: begin
          if (released) begin
            busy_q  <= 1'b0;
            state_q <= HS_IDLE;
          end
        end
        default: state_q <= HS_IDLE;
      endcase
    end
  end

  logic fire;
  assign fire       = (state_q == HS_WAIT) && !released && go;
  assign addr_stb_o = fire && is_addr_q;
  assign data_stb_o = fire && !is_addr_q;
  assign rd_o       = rd_q;
  assign busy_o     = busy_q;
  assign drive_o    = busy_q && rd_q && !is_addr_q;

  assert_busy_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(!astb_n_s_i || !dstb_n_s_i));
  assert_busy_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(astb_n_s_i && dstb_n_s_i));
  assert_status_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == HS_WAIT && !is_addr_q && acc_high_i && running_i && !int_ack_i)
      |=> !busy_o);
endmodule

// File: rtl/epp_regfile.sv
module epp_regfile
  import epp_bridge_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BUS_W-1:0] data_i,
  input  logic             addr_stb_i,
  input  logic             data_stb_i,
  input  logic             rd_i,
  input  logic             run_flag_i,
  input  logic             err_flag_i,
  input  logic             smp_chan_i,
  input  logic [SMP_W-1:0] sample_i,
  input  logic [ERR_W-1:0] err_num_i,
  output logic             acc_high_o,
  output logic [BUS_W-1:0] rd_byte_o,
  output logic [RUN_W-1:0] run_cfg_o,
  output logic [CH_W-1:0]  chan_mask_o,
  output logic [BUF_W-1:0] buf_size_o,
  output logic [LVL_W-1:0] trig_level_o,
  output logic [OFS_W-1:0] trig_offset_o,
  output logic [ADC_W-1:0] adc_cfg_o
);
  logic [BUS_W-1:0]  addr_q, stage_q, snap_hi_q, rd_byte_q;
  logic              hi_sel_q;
  logic [WORD_W-1:0] rd_word, wr_word;

  assign wr_word = {data_i, stage_q};

  always_comb begin
    rd_word = '0;
    case (addr_q)
      A_RUN:  rd_word[RUN_W-1:0] = run_cfg_o;
      A_CHAN: rd_word[CH_W-1:0]  = chan_mask_o;
      A_BUF:  rd_word[BUF_W-1:0] = buf_size_o;
      A_LVL:  rd_word[LVL_W-1:0] = trig_level_o;
      A_OFS:  rd_word[OFS_W-1:0] = trig_offset_o;
      A_ADC:  rd_word[ADC_W-1:0] = adc_cfg_o;
      A_STAT: begin
        rd_word[15]        = err_flag_i;
        rd_word[14]        = run_flag_i;
        rd_word[10]        = smp_chan_i;
        rd_word[SMP_W-1:0] = sample_i;
      end
      A_ERR:  rd_word[ERR_W-1:0] = err_num_i;
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q        <= '0;
      stage_q       <= '0;
      snap_hi_q     <= '0;
      rd_byte_q     <= '0;
      hi_sel_q      <= 1'b0;
      run_cfg_o     <= '0;
      chan_mask_o   <= '0;
      buf_size_o    <= '0;
      trig_level_o  <= '0;
      trig_offset_o <= '0;
      adc_cfg_o     <= '0;
    end else if (addr_stb_i) begin
      if (!rd_i) addr_q <= data_i;
      hi_sel_q <= 1'b0;
    end else if (data_stb_i) begin
      hi_sel_q <= !hi_sel_q;
      if (rd_i) begin
        if (!hi_sel_q) begin
          rd_byte_q <= rd_word[BUS_W-1:0];
          snap_hi_q <= rd_word[WORD_W-1:BUS_W];
        end else begin
          rd_byte_q <= snap_hi_q;
        end
      end else if (!hi_sel_q) begin
        stage_q <= data_i;
      end else begin
        case (addr_q)
          A_RUN:  run_cfg_o     <= wr_word[RUN_W-1:0];
          A_CHAN: chan_mask_o   <= wr_word[CH_W-1:0];
          A_BUF:  buf_size_o    <= wr_word[BUF_W-1:0];
          A_LVL:  trig_level_o  <= wr_word[LVL_W-1:0];
          A_OFS:  trig_offset_o <= wr_word[OFS_W-1:0];
          A_ADC:  adc_cfg_o     <= wr_word[ADC_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign acc_high_o = addr_q[STAT_BIT];
  assign rd_byte_o  = rd_byte_q;

  assert_cfg_only_on_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(data_stb_i && !rd_i && hi_sel_q)
      |=> $stable({run_cfg_o, chan_mask_o, buf_size_o, trig_level_o, trig_offset_o, adc_cfg_o}));
  assert_order_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_stb_i |=> !hi_sel_q);
endmodule

// File: rtl/epp_reg_bridge.sv
module epp_reg_bridge
  import epp_bridge_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             epp_write_ni,
  input  logic             epp_astb_ni,
  input  logic             epp_dstb_ni,
  input  logic [BUS_W-1:0] epp_data_i,
  output logic [BUS_W-1:0] epp_data_o,
  output logic             epp_data_oe_o,
  output logic             epp_busy_o,
  input  logic             running_i,
  input  logic             stat_ack_i,
  input  logic             run_flag_i,
  input  logic             err_flag_i,
  input  logic             smp_chan_i,
  input  logic [SMP_W-1:0] sample_i,
  input  logic [ERR_W-1:0] err_num_i,
  output logic [RUN_W-1:0] run_cfg_o,
  output logic [CH_W-1:0]  chan_mask_o,
  output logic [BUF_W-1:0] buf_size_o,
  output logic [LVL_W-1:0] trig_level_o,
  output logic [OFS_W-1:0] trig_offset_o,
  output logic [ADC_W-1:0] adc_cfg_o
);
  logic [2:0] ctl_s;
  logic       addr_stb, data_stb, rd, acc_high;

  epp_sync #(.W(3), .STAGES(2), .RST_VAL(3'b111)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({epp_write_ni, epp_astb_ni, epp_dstb_ni}),
    .q_o    (ctl_s)
  );

  epp_handshake u_hs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .astb_n_s_i  (ctl_s[1]),
    .dstb_n_s_i  (ctl_s[0]),
    .write_n_s_i (ctl_s[2]),
    .acc_high_i  (acc_high),
    .running_i   (running_i),
    .int_ack_i   (stat_ack_i),
    .busy_o      (epp_busy_o),
    .addr_stb_o  (addr_stb),
    .data_stb_o  (data_stb),
    .rd_o        (rd),
    .drive_o     (epp_data_oe_o)
  );

  epp_regfile u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .data_i        (epp_data_i),
    .addr_stb_i    (addr_stb),
    .data_stb_i    (data_stb),
    .rd_i          (rd),
    .run_flag_i    (run_flag_i),
    .err_flag_i    (err_flag_i),
    .smp_chan_i    (smp_chan_i),
    .sample_i      (sample_i),
    .err_num_i     (err_num_i),
    .acc_high_o    (acc_high),
    .rd_byte_o     (epp_data_o),
    .run_cfg_o     (run_cfg_o),
    .chan_mask_o   (chan_mask_o),
    .buf_size_o    (buf_size_o),
    .trig_level_o  (trig_level_o),
    .trig_offset_o (trig_offset_o),
    .adc_cfg_o     (adc_cfg_o)
  );

  assert_oe_in_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    epp_data_oe_o |-> epp_busy_o);
endmodule

// File: tb/epp_reg_bridge_test.sv
module epp_reg_bridge_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic write_n = 1'b0, astb_n = 1'b1, dstb_n = 1'b1;
  logic [7:0] data_in = '0;
  logic [7:0] data_out;
  logic oe, busy;
  logic running = 1'b0, stat_ack = 1'b0;
  logic run_flag = 1'b0, err_flag = 1'b0, smp_chan = 1'b0;
  logic [9:0] sample = '0;
  logic [2:0] err_num = '0;
  logic [10:0] run_cfg;
  logic [1:0]  chan_mask;
  logic [13:0] buf_size;
  logic [9:0]  trig_level;
  logic [14:0] trig_offset;
  logic [11:0] adc_cfg;

  int checks = 0;
  int errors = 0;
  logic [7:0]  exp_q[$];
  string       tag_q[$];
  int          cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  epp_reg_bridge uut (
    .clk_i(clk), .rst_ni(rst_n),
    .epp_write_ni(write_n), .epp_astb_ni(astb_n), .epp_dstb_ni(dstb_n),
    .epp_data_i(data_in), .epp_data_o(data_out), .epp_data_oe_o(oe), .epp_busy_o(busy),
    .running_i(running), .stat_ack_i(stat_ack),
    .run_flag_i(run_flag), .err_flag_i(err_flag), .smp_chan_i(smp_chan),
    .sample_i(sample), .err_num_i(err_num),
    .run_cfg_o(run_cfg), .chan_mask_o(chan_mask), .buf_size_o(buf_size),
    .trig_level_o(trig_level), .trig_offset_o(trig_offset), .adc_cfg_o(adc_cfg)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: compare each driven read byte with the scoreboard
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (oe && !oe_prev) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R5: unexpected read byte actual 0x%0h expected none", data_out);
      end else begin
        check(tag_q.pop_front(), {24'd0, data_out}, {24'd0, exp_q.pop_front()});
      end
    end
    oe_prev = oe;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  task automatic wait_busy(input logic lvl, input string req);
    int n = 0;
    while (busy !== lvl && n < 100) begin
      @(negedge clk); n++;
    end
    if (busy !== lvl) begin
      checks++; errors++;
      $display("FAIL %s: busy actual %0b expected %0b", req, busy, lvl);
    end
  endtask

  task automatic epp_cycle(input logic is_addr, input logic wr, input logic [7:0] b);
    @(negedge clk);
    write_n = !wr;
    if (wr) data_in = b;
    if (is_addr) astb_n = 1'b0; else dstb_n = 1'b0;
    wait_busy(1'b1, "R2");
    @(negedge clk);
    astb_n = 1'b1; dstb_n = 1'b1;
    wait_busy(1'b0, "R2");
  endtask

  task automatic host_write(input logic [7:0] a, input logic [15:0] d);
    epp_cycle(1'b1, 1'b1, a);
    epp_cycle(1'b0, 1'b1, d[7:0]);
    epp_cycle(1'b0, 1'b1, d[15:8]);
  endtask

  task automatic host_read(input logic [7:0] a, input logic [15:0] exp, input string req);
    epp_cycle(1'b1, 1'b1, a);
    exp_q.push_back(exp[7:0]);  tag_q.push_back(req);
    exp_q.push_back(exp[15:8]); tag_q.push_back(req);
    epp_cycle(1'b0, 1'b0, 8'h00);
    epp_cycle(1'b0, 1'b0, 8'h00);
  endtask

  task automatic check_regs(input string req, input logic [10:0] r0, input logic [1:0] r1,
                            input logic [13:0] r2, input logic [9:0] r3,
                            input logic [14:0] r4, input logic [11:0] r5);
    check(req, {21'd0, run_cfg}, {21'd0, r0});
    check(req, {30'd0, chan_mask}, {30'd0, r1});
    check(req, {18'd0, buf_size}, {18'd0, r2});
    check(req, {22'd0, trig_level}, {22'd0, r3});
    check(req, {17'd0, trig_offset}, {17'd0, r4});
    check(req, {20'd0, adc_cfg}, {20'd0, r5});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check_regs("R1", '0, '0, '0, '0, '0, '0);
    check("R1", {31'd0, busy}, 0);
    check("R1", {31'd0, oe}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 handshake timing on an address cycle
    begin
      int n = 0;
      write_n = 1'b0; data_in = 8'h02; astb_n = 1'b0;
      while (!busy && n < 50) begin @(negedge clk); n++; end
      check("R2 rise delay>=2", {31'd0, n >= 2}, 1);
      astb_n = 1'b1;
      @(negedge clk);
      check("R2 held after release", {31'd0, busy}, 1);
      wait_busy(1'b0, "R2");
    end

    // R3 low byte alone leaves the register untouched (address 2 already selected)
    epp_cycle(1'b0, 1'b1, 8'h34);
    check("R3 after low byte", {18'd0, buf_size}, 0);
    epp_cycle(1'b0, 1'b1, 8'h12);
    check("R3 after high byte", {18'd0, buf_size}, 32'h1234);

    // R4 truncation with all-ones and mixed patterns
    host_write(8'd0, 16'hFFFF);
    host_write(8'd1, 16'hFFFF);
    host_write(8'd3, 16'hA5C3);
    host_write(8'd4, 16'hFFFF);
    host_write(8'd5, 16'h5A5C);
    check_regs("R4", 11'h7FF, 2'h3, 14'h1234, 10'h1C3, 15'h7FFF, 12'hA5C);

    // R5 read back, bytes in order, unused bits zero (R4)
    host_read(8'd0, 16'h07FF, "R5 R4 addr0");
    host_read(8'd3, 16'h01C3, "R5 R4 addr3");
    host_read(8'd5, 16'h0A5C, "R5 R4 addr5");

    // R6 status words
    sample = 10'h2AB; smp_chan = 1'b1; run_flag = 1'b1; err_flag = 1'b0; err_num = 3'd5;
    host_read(8'd8, 16'h46AB, "R6 addr8");
    host_read(8'd9, 16'h0005, "R6 addr9");
    err_flag = 1'b1; run_flag = 1'b0; smp_chan = 1'b0; sample = 10'h001;
    host_read(8'd8, 16'h8001, "R6 addr8 flags");

    // R7 unmapped reads and ignored writes
    host_read(8'd7, 16'h0000, "R7 addr7");
    host_read(8'd200, 16'h0000, "R7 addr200");
    host_write(8'd8, 16'hFFFF);
    host_write(8'd6, 16'h0000);
    check_regs("R7", 11'h7FF, 2'h3, 14'h1234, 10'h1C3, 15'h7FFF, 12'hA5C);

    // R8 stall on status while running without acknowledge
    running = 1'b1; stat_ack = 1'b0;
    host_write(8'd1, 16'h0001);
    check("R8 low address no wait", {30'd0, chan_mask}, 1);
    epp_cycle(1'b1, 1'b1, 8'd9);
    exp_q.push_back(8'h05); tag_q.push_back("R8 stalled read");
    @(negedge clk);
    write_n = 1'b1; dstb_n = 1'b0;
    repeat (20) @(negedge clk);
    check("R8 busy while waiting", {31'd0, busy}, 0);
    stat_ack = 1'b1;
    wait_busy(1'b1, "R8");
    @(negedge clk);
    dstb_n = 1'b1;
    wait_busy(1'b0, "R8");
    exp_q.push_back(8'h00); tag_q.push_back("R8 stalled read");
    epp_cycle(1'b0, 1'b0, 8'h00);
    running = 1'b0; stat_ack = 1'b0;

    // R9 orphan low byte, then new address restarts order
    epp_cycle(1'b1, 1'b1, 8'd1);
    epp_cycle(1'b0, 1'b1, 8'hEE);
    host_write(8'd3, 16'h0122);
    check("R9 new target", {22'd0, trig_level}, 32'h122);
    check("R9 old target", {30'd0, chan_mask}, 1);

    repeat (5) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R5: pending bytes actual %0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule